// File: doc/BRIEF.md
# Network interface control and status register block

This block gives a host on a 36-bit I/O bus its control and status view of a packet network interface. A control write latches the interrupt level, the two interrupt enables, the accept-any-destination flag, the last-word flag for the next data write, and the byte-order mode. The same write can also set the transmit-done flag and issue one-cycle start and initialise commands. A status read returns one 36-bit word. That word combines the latched control state with the transmitter and receiver flags, the lost-packet count and the receive bit count, which the surrounding data path supplies as inputs.

An interrupt is requested when a completed receive has its enable set, or when a completed transmit has its enable set. The request is decoded onto one of seven active-low open-collector priority lines, chosen by a 3-bit level. Level zero drives no line. The request is not vectored.

Top module: `nic_ctl_status`

## Requirements
- R1: After reset, the level, both enables, transmit done, match-any, last-word and mode are all zero. No interrupt line is driven low, and neither command pulse is high.
- R2: On a control write, the latched fields load from these control bits and read back at the same status positions from the next cycle: level [2:0], transmit enable [5], receive enable [8], match-any [9], last-word [10], mode [11] (1 = 8-bit, 0 = 16-bit).
- R3: Transmit done is status bit [3]. A control write with bit [3] = 1 sets it. A one-cycle `tx_finish` pulse also sets it. A write with start bit [6] = 1 clears it, unless bit [3] is also 1, in which case it ends up set. A write with bits [3] and [6] both 0 leaves it unchanged.
- R4: A control write with bit [6] = 1 makes `start_pulse` high for exactly the cycle after the write edge.
- R5: A control write with bit [12] = 1 makes `init_pulse` high for one cycle. It clears the level, both enables, match-any, last-word and mode, whatever the other bits of that word hold. It leaves transmit done unchanged.
- R6: Control bits [4], [7] and [35:13] other than [12] have no effect on the status word or on the command pulses.
- R7: The status word carries these inputs combinationally: transmit busy [4], receive done [6], receive active [7], CW [12], CRC error [13], transmit abort [14], the sign of the 13-bit receive count [17], the lost count [21:18] and the low 12 count bits [35:24]. Bits [16:15] and [23:22] read zero.
- R8: `pi_req_n[k]` (k = 1..7) is low exactly when the level equals k and (receive done AND receive enable) OR (transmit done AND transmit enable) holds. All other lines stay high, and level 0 drives none.
- R9: Without a control write, the latched fields and transmit done hold their values, whatever `ctl_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 36 | Control word |
| tx_finish | input | 1 | Transmitter completion pulse |
| tx_busy | input | 1 | Transmitter busy |
| tx_abort | input | 1 | Last transmit aborted |
| rx_done | input | 1 | Receive complete |
| rx_active | input | 1 | Receive in progress |
| cw_flag | input | 1 | CW status from receiver |
| crc_err | input | 1 | Receive CRC error |
| lost_count | input | 4 | Lost-packet count |
| rx_bitcnt | input | 13 | Signed receive bit count |
| status_word | output | 36 | Assembled status word |
| pi_req_n | output | 7 | Active-low interrupt lines 7..1 |
| start_pulse | output | 1 | One-cycle transmit start |
| init_pulse | output | 1 | One-cycle initialise |
| mode8 | output | 1 | 8-bit byte-order mode |
| match_any | output | 1 | Accept any destination |
| last_word | output | 1 | Next data write is the last word |

## Verification
The bench builds the block with its default widths: a 3-bit level, a 4-bit lost count and a 13-bit receive count. With these defaults, every level from 0 to 7 is swept against all sixteen combinations of the two done flags and the two enables, so each line of the decode is covered. Because the count and lost-count inputs are this narrow, the bench drives their extremes and walking patterns directly into the status word.

// File: rtl/nic_ctl_status.sv
module nic_ctl_status #(
  parameter int PIA_W  = 3,
  parameter int LOST_W = 4,
  parameter int CNT_W  = 13,
  localparam int WORD_W = (CNT_W - 1) + 2 + LOST_W + 1 + 2 + 12 + PIA_W,
  localparam int LINES  = (1 << PIA_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_data,
  input  logic              tx_finish,
  input  logic              tx_busy,
  input  logic              tx_abort,
  input  logic              rx_done,
  input  logic              rx_active,
  input  logic              cw_flag,
  input  logic              crc_err,
  input  logic [LOST_W-1:0] lost_count,
  input  logic [CNT_W-1:0]  rx_bitcnt,
  output logic [WORD_W-1:0] status_word,
  output logic [LINES:1]    pi_req_n,
  output logic              start_pulse,
  output logic              init_pulse,
  output logic              mode8,
  output logic              match_any,
  output logic              last_word
);
  localparam int B_TXSET = PIA_W;
  localparam int B_TIEN  = PIA_W + 2;
  localparam int B_GO    = PIA_W + 3;
  localparam int B_RIEN  = PIA_W + 5;
  localparam int B_MATCH = PIA_W + 6;
  localparam int B_LAST  = PIA_W + 7;
  localparam int B_MODE  = PIA_W + 8;
  localparam int B_INIT  = PIA_W + 9;

  logic [PIA_W-1:0] pia_q;
  logic tien_q, rien_q, txd_q, irq;

  wire do_init = ctl_wr & ctl_data[B_INIT];
  wire do_go   = ctl_wr & ctl_data[B_GO];
  wire do_set  = ctl_wr & ctl_data[B_TXSET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pia_q     <= '0;
      tien_q    <= 1'b0;
      rien_q    <= 1'b0;
      match_any <= 1'b0;
      last_word <= 1'b0;
      mode8     <= 1'b0;
    end else if (do_init) begin
      pia_q     <= '0;
      tien_q    <= 1'b0;
      rien_q    <= 1'b0;
      match_any <= 1'b0;
      last_word <= 1'b0;
      mode8     <= 1'b0;
    end else if (ctl_wr) begin
      pia_q     <= ctl_data[PIA_W-1:0];
      tien_q    <= ctl_data[B_TIEN];
      rien_q    <= ctl_data[B_RIEN];
      match_any <= ctl_data[B_MATCH];
      last_word <= ctl_data[B_LAST];
      mode8     <= ctl_data[B_MODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q       <= 1'b0;
      start_pulse <= 1'b0;
      init_pulse  <= 1'b0;
    end else begin
      txd_q       <= (txd_q & ~do_go) | do_set | tx_finish;
      start_pulse <= do_go;
      init_pulse  <= do_init;
    end
  end

  assign irq = (rx_done & rien_q) | (txd_q & tien_q);

  for (genvar k = 1; k <= LINES; k++) begin : g_line
    assign pi_req_n[k] = ~(irq && (pia_q == PIA_W'(k)));
  end

  assign status_word = {rx_bitcnt[CNT_W-2:0], 2'b00, lost_count, rx_bitcnt[CNT_W-1],
                        2'b00, tx_abort, crc_err, cw_flag, mode8, last_word, match_any,
                        rien_q, rx_active, rx_done, tien_q, tx_busy, txd_q, pia_q};
endmodule

module nic_ctl_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [35:0] ctl_data,
  input logic [35:0] status_word,
  input logic [7:1]  pi_req_n,
  input logic        start_pulse,
  input logic        init_pulse
);
  logic [7:0] lines_ext;
  logic       req_expected;
  assign lines_ext    = {pi_req_n, 1'b1};
  assign req_expected = (status_word[6] & status_word[8]) | (status_word[3] & status_word[5]);

  assert_level0_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[2:0] == 3'd0) |-> (&pi_req_n));

  assert_line_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_expected && status_word[2:0] != 3'd0) |-> !lines_ext[status_word[2:0]]);

  assert_single_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~pi_req_n) <= 1);

  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_data[6] |=> start_pulse);

  assert_init_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |-> (status_word[2:0] == 3'd0 && !status_word[5] && status_word[11:8] == 4'd0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && !$past(ctl_wr) |-> $stable(status_word[2:0]) && $stable(status_word[5])
                                  && $stable(status_word[11:8]));
endmodule

bind nic_ctl_status nic_ctl_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .status_word(status_word), .pi_req_n(pi_req_n),
  .start_pulse(start_pulse), .init_pulse(init_pulse));

// File: tb/nic_ctl_status_tb.sv
module nic_ctl_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0;
  logic [35:0] ctl_data = '0;
  logic tx_finish = 0, tx_busy = 0, tx_abort = 0, rx_done = 0, rx_active = 0, cw_flag = 0, crc_err = 0;
  logic [3:0] lost_count = '0;
  logic [12:0] rx_bitcnt = '0;
  logic [35:0] status_word;
  logic [7:1] pi_req_n;
  logic start_pulse, init_pulse, mode8, match_any, last_word;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] m_pia = 0;
  logic m_tien = 0, m_rien = 0, m_match = 0, m_last = 0, m_mode = 0, m_txd = 0;

  always #4 clk = ~clk;

  nic_ctl_status dut_i (.*);

  function automatic logic [35:0] exp_status();
    return {rx_bitcnt[11:0], 2'b00, lost_count, rx_bitcnt[12], 2'b00, tx_abort, crc_err, cw_flag,
            m_mode, m_last, m_match, m_rien, rx_active, rx_done, m_tien, tx_busy, m_txd, m_pia};
  endfunction

  function automatic logic [7:1] exp_lines();
    logic [7:1] r = '1;
    logic req = (rx_done & m_rien) | (m_txd & m_tien);
    for (int k = 1; k <= 7; k++) if (req && m_pia == k) r[k] = 1'b0;
    return r;
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [35:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = w;
    @(negedge clk); ctl_wr = 1'b0; ctl_data = ~w;
    if (w[12]) begin
      m_pia = 0; m_tien = 0; m_rien = 0; m_match = 0; m_last = 0; m_mode = 0;
    end else begin
      m_pia = w[2:0]; m_tien = w[5]; m_rien = w[8]; m_match = w[9]; m_last = w[10]; m_mode = w[11];
    end
    if (w[6]) m_txd = 0;
    if (w[3]) m_txd = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] ign, s1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status_word, exp_status());
    chk("R1 lines", {29'd0, pi_req_n}, {29'd0, 7'h7f});
    chk("R1 pulses", {34'd0, start_pulse, init_pulse}, 36'd0);

    wr(36'h0000_0EFF & ~36'h0000_0090 | 36'h7);
    chk("R2 load all", status_word, exp_status());
    chk("R2 outputs", {33'd0, mode8, match_any, last_word}, {33'd0, 3'b111});
    wr(36'h0000_0A25);
    chk("R2 partial", status_word, exp_status());

    wr(36'h0000_0008);
    chk("R3 set by bit3", status_word, exp_status());
    chk("R4 no pulse without bit6", {35'd0, start_pulse}, 36'd0);
    wr(36'h0000_0000);
    chk("R3 hold on plain write", status_word, exp_status());
    wr(36'h0000_0040);
    chk("R4 start pulse", {35'd0, start_pulse}, 36'd1);
    chk("R3 cleared by start", status_word, exp_status());
    @(negedge clk);
    chk("R4 pulse one cycle", {35'd0, start_pulse}, 36'd0);
    wr(36'h0000_0048);
    chk("R3 set wins over start", status_word, exp_status());
    wr(36'h0000_0040);
    @(negedge clk); tx_finish = 1; @(negedge clk); tx_finish = 0; m_txd = 1;
    chk("R3 set by tx_finish", status_word, exp_status());

    wr(36'h0000_0F27);
    wr(36'h0000_1F27);
    chk("R5 init pulse", {35'd0, init_pulse}, 36'd1);
    chk("R5 init clears", status_word, exp_status());
    @(negedge clk);
    chk("R5 pulse one cycle", {35'd0, init_pulse}, 36'd0);

    ign = 36'hF_FFFF_E090;
    wr(36'h0000_0B26);
    s1 = status_word;
    wr(36'h0000_0B26 | ign);
    chk("R6 ignored bits", status_word, s1);
    chk("R6 no pulses", {34'd0, start_pulse, init_pulse}, 36'd0);

    s1 = status_word;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ctl_data = {6{6'(i * 11 + 5)}};
    end
    chk("R9 hold without write", status_word, s1);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {tx_busy, rx_active, cw_flag, crc_err, tx_abort} = 5'(i * 13 + 7);
      lost_count = (i == 0) ? 4'hF : 4'(1 << (i % 4));
      rx_bitcnt  = (i == 1) ? 13'h1FFF : (i == 2) ? 13'h1000 : 13'((i * 911) ^ 13'h0A5A);
      rx_done = i[0];
      #1 chk("R7 input fields", status_word, exp_status());
    end
    rx_done = 0;

    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [35:0] w = 36'(p);
        w[5] = c[0]; w[8] = c[1];
        if (c[2]) w[3] = 1'b1; else w[6] = 1'b1;
        @(negedge clk); rx_done = c[3];
        wr(w);
        chk("R8 decode lines", {29'd0, pi_req_n}, {29'd0, exp_lines()});
        chk("R2 level and enables", status_word, exp_status());
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule